// File: doc/BRIEF.md
# Extended Indirect Address Translator

This block resolves the physical destination of an indirect memory access made through a relocatable zero page. When the zero page sits inside a small window of pages, each pointer in it has a companion extension byte stored at a fixed offset from the pointer. The translator fetches that byte through its own memory read port and uses its value to choose how the 16-bit indirect target is mapped. The choices are a special system mapping, an explicit user bank, a range-driven system map, or the zero-page-only rule for any other value.

A requester presents the zero-page page number, the pointer's byte offset within the zero page, the 16-bit target and the current user bank. The translator registers all of them on acceptance. It then issues one extension read, captures the returned byte and presents a bank, an offset and a status for one cycle. If the zero page lies outside the window, no read is made and the request is reported as falling back to normal mapping.

Top module: `ext_ind_xlat`

## Requirements
- R1: After reset `ready_o` is 1 and both `ext_rd_o` and `done_o` are 0.
- R2: A request accepted with `zp_page_i` in 0x18..0x1F raises `ext_rd_o` in the next cycle. With any other page, no read is made. `done_o` is raised in the next cycle with status 3 (fallback), bank 0x00 and the offset equal to the target.
- R3: During the read cycle, `ext_addr_o` equals `{zp_page, zp_ptr} ^ 0x0C00`. `ext_data_i` is sampled in the cycle after the read, and `done_o` is high in the cycle after that. Status codes are 0 mapped, 1 unmapped, 2 rom and 3 fallback. Bank 0xFF means the system bank.
- R4: Extension 0x8F maps as follows:
  - Targets 0xFFD0..0xFFEF go to the system bank at target & 0x7FFF.
  - Targets below 0x2000 go to the system bank at target − 0x2000, modulo 2^16.
  - Targets above 0x9FFF go to the system bank at target − 0x8000.
  - The remaining targets go to bank 0x00 (linear RAM) at target − 0x2000.
  - All of these report status mapped.
- R5: Extension 0x80..0x8E maps targets below 0x0100 to the system bank at `{zp_page, target[7:0]}`. All other targets go to the bank equal to the extension byte, at the unchanged target. The status is mapped.
- R6: Extension 0xFF maps by target range:
  - Below 0x2000 goes to the system bank at target − 0x2000.
  - Below 0xA000 goes to the user bank at target − 0x2000.
  - Below 0xC000 goes to the system bank at target − 0x8000.
  - 0xC000..0xCFFF is unmapped, with bank 0x00 and the target as the offset.
  - 0xD000..0xEFFF goes to the system bank at target − 0x8000.
  - 0xF000 and above reports rom, with bank 0xFF and the target as the offset.
- R7: Any other extension value maps targets below 0x0100 to the system bank at `{zp_page, target[7:0]}`. All other targets are unmapped, with bank 0x00 and the target as the offset.
- R8: `ready_o` is high only while idle. `done_o` lasts exactly one cycle. A request held during a busy cycle, including the `done_o` cycle, is not accepted; it is accepted in the first idle cycle after.
- R9: Changes to `target_i`, `zp_page_i`, `zp_ptr_i` and `user_bank_i` after acceptance have no effect on the result. Changes to `ext_data_i` outside its sampling cycle also have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Translation request |
| zp_page_i | input | 8 | Page where the zero page currently lives |
| zp_ptr_i | input | 8 | Byte offset of the pointer inside the zero page |
| target_i | input | 16 | Indirect target offset |
| user_bank_i | input | 8 | Current user bank |
| ready_o | output | 1 | Idle, a request will be accepted |
| ext_rd_o | output | 1 | Extension byte read strobe |
| ext_addr_o | output | 16 | System-bank address of the extension byte |
| ext_data_i | input | 8 | Extension byte, valid the cycle after the strobe |
| done_o | output | 1 | One-cycle result strobe |
| bank_o | output | 8 | Result bank (0xFF system) |
| offset_o | output | 16 | Result offset within the bank |
| status_o | output | 2 | 0 mapped, 1 unmapped, 2 rom, 3 fallback |

## Verification
Two things can land in the same cycle. A requester may hold `req_i` high through the `done_o` cycle, so the result strobe and a would-be acceptance coincide. The bench keeps `req_i` asserted across a whole transaction. It then checks that `done_o` carries the first result, that `ready_o` stays low in that cycle, and that the second read strobe appears only two cycles later. The capture of `ext_data_i` must also coincide with the requester scrambling its other inputs. The bench changes every request input in the read cycle, and drives junk extension data in the done cycle. It then confirms that the result matches the originally accepted values.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned BANK_W = 8;

  localparam logic [BANK_W-1:0] BANK_SYS = 8'hFF;
  localparam logic [BANK_W-1:0] BANK_RAW = 8'h00;

  typedef enum logic [1:0] {
    ST_MAPPED   = 2'd0,
    ST_UNMAPPED = 2'd1,
    ST_ROM      = 2'd2,
    ST_FALLBACK = 2'd3
  } xlat_status_e;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_RD   = 2'd1,
    S_CAP  = 2'd2,
    S_RESP = 2'd3
  } xlat_state_e;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ADDR_W-1:0] offset;
    xlat_status_e      status;
  } xlat_result_t;
endpackage

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
  import xlat_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic in_win_i,
  output logic ready_o,
  output logic accept_o,
  output logic rd_o,
  output logic cap_o,
  output logic done_o
);
  xlat_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE: if (req_i) state_d = in_win_i ? S_RD : S_RESP;
      S_RD:   state_d = S_CAP;
      S_CAP:  state_d = S_RESP;
      S_RESP: state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign ready_o  = (state_q == S_IDLE);
  assign accept_o = ready_o & req_i;
  assign rd_o     = (state_q == S_RD);
  assign cap_o    = (state_q == S_CAP);
  assign done_o   = (state_q == S_RESP);

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_cap_after_rd_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_o |=> cap_o);
endmodule

// File: rtl/xlat_map.sv
module xlat_map
  import xlat_pkg::*;
(
  input  logic              fallback_i,
  input  logic [7:0]        ext_i,
  input  logic [7:0]        zp_page_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [BANK_W-1:0] user_bank_i,
  output xlat_result_t      res_o
);
  localparam logic [7:0] EXT_SPECIAL = 8'h8F;
  localparam logic [7:0] EXT_SYSMAP  = 8'hFF;
  localparam logic [7:0] EXT_UB_LO   = 8'h80;
  localparam logic [7:0] EXT_UB_HI   = 8'h8E;

  logic [ADDR_W-1:0] minus_2k, minus_8k, zp_rel;

  assign minus_2k = target_i - 16'h2000;
  assign minus_8k = target_i - 16'h8000;
  assign zp_rel   = {zp_page_i, target_i[7:0]};

  always_comb begin
    res_o = '{bank: BANK_RAW, offset: target_i, status: ST_UNMAPPED};
    if (fallback_i) begin
      res_o.status = ST_FALLBACK;
    end else if (ext_i == EXT_SPECIAL) begin
      res_o.status = ST_MAPPED;
      res_o.bank   = BANK_SYS;
      if (target_i >= 16'hFFD0 && target_i <= 16'hFFEF) begin
        res_o.offset = target_i & 16'h7FFF;
      end else if (target_i < 16'h2000) begin
        res_o.offset = minus_2k;
      end else if (target_i > 16'h9FFF) begin
        res_o.offset = minus_8k;
      end else begin
        res_o.bank   = BANK_RAW;
        res_o.offset = minus_2k;
      end
    end else if (ext_i >= EXT_UB_LO && ext_i <= EXT_UB_HI) begin
      res_o.status = ST_MAPPED;
      if (target_i < 16'h0100) begin
        res_o.bank   = BANK_SYS;
        res_o.offset = zp_rel;
      end else begin
        res_o.bank   = ext_i;
      end
    end else if (ext_i == EXT_SYSMAP) begin
      if (target_i < 16'h2000) begin
        res_o = '{bank: BANK_SYS, offset: minus_2k, status: ST_MAPPED};
      end else if (target_i < 16'hA000) begin
        res_o = '{bank: user_bank_i, offset: minus_2k, status: ST_MAPPED};
      end else if (target_i < 16'hC000) begin
        res_o = '{bank: BANK_SYS, offset: minus_8k, status: ST_MAPPED};
      end else if (target_i < 16'hD000) begin
        res_o.status = ST_UNMAPPED;
      end else if (target_i < 16'hF000) begin
        res_o = '{bank: BANK_SYS, offset: minus_8k, status: ST_MAPPED};
      end else begin
        res_o = '{bank: BANK_SYS, offset: target_i, status: ST_ROM};
      end
    end else if (target_i < 16'h0100) begin
      res_o = '{bank: BANK_SYS, offset: zp_rel, status: ST_MAPPED};
    end
  end

  always_comb begin
    if (res_o.status == ST_ROM) begin
      a_rom_sys_r6: assert (res_o.bank == BANK_SYS);
    end
  end
endmodule

// File: rtl/ext_ind_xlat.sv
module ext_ind_xlat
  import xlat_pkg::*;
#(
  parameter logic [7:0]  WIN_LO   = 8'h18,
  parameter logic [7:0]  WIN_HI   = 8'h1F,
  parameter logic [15:0] EXT_XOR  = 16'h0C00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [7:0]        zp_page_i,
  input  logic [7:0]        zp_ptr_i,
  input  logic [ADDR_W-1:0] target_i,
  input  logic [BANK_W-1:0] user_bank_i,
  output logic              ready_o,
  output logic              ext_rd_o,
  output logic [ADDR_W-1:0] ext_addr_o,
  input  logic [7:0]        ext_data_i,
  output logic              done_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [ADDR_W-1:0] offset_o,
  output logic [1:0]        status_o
);
  logic in_win, accept, cap;
  logic [7:0]        zp_page_q, zp_ptr_q, ext_q;
  logic [ADDR_W-1:0] target_q;
  logic [BANK_W-1:0] ubank_q;
  logic              fb_q;
  xlat_result_t      res;

  assign in_win = (zp_page_i >= WIN_LO) && (zp_page_i <= WIN_HI);

  xlat_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .in_win_i (in_win),
    .ready_o  (ready_o),
    .accept_o (accept),
    .rd_o     (ext_rd_o),
    .cap_o    (cap),
    .done_o   (done_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      zp_page_q <= '0;
      zp_ptr_q  <= '0;
      target_q  <= '0;
      ubank_q   <= '0;
      fb_q      <= 1'b0;
    end else if (accept) begin
      zp_page_q <= zp_page_i;
      zp_ptr_q  <= zp_ptr_i;
      target_q  <= target_i;
      ubank_q   <= user_bank_i;
      fb_q      <= !in_win;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  ext_q <= '0;
    else if (cap) ext_q <= ext_data_i;
  end

  assign ext_addr_o = {zp_page_q, zp_ptr_q} ^ EXT_XOR;

  xlat_map u_map (
    .fallback_i  (fb_q),
    .ext_i       (ext_q),
    .zp_page_i   (zp_page_q),
    .target_i    (target_q),
    .user_bank_i (ubank_q),
    .res_o       (res)
  );

  assign bank_o   = res.bank;
  assign offset_o = res.offset;
  assign status_o = res.status;

  p_win_read_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && in_win) |=> ext_rd_o);
  p_fallback_fast_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o && !in_win) |=> (done_o && !ext_rd_o && status_o == ST_FALLBACK));
  p_rd_to_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rd_o |-> ##2 done_o);
  p_busy_in_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !ready_o);
  p_hold_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !done_o) |=> $stable(ext_addr_o));
endmodule

// File: tb/tb_ext_ind_xlat.sv
`timescale 1ns/1ps
module tb_ext_ind_xlat;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [7:0]  zp_page = '0, zp_ptr = '0, ubank = '0, ext_data = '0;
  logic [15:0] target = '0;
  logic        ready, ext_rd, done;
  logic [15:0] ext_addr, offset;
  logic [7:0]  bank;
  logic [1:0]  status;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  ext_ind_xlat dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .zp_page_i(zp_page),
    .zp_ptr_i(zp_ptr), .target_i(target), .user_bank_i(ubank),
    .ready_o(ready), .ext_rd_o(ext_rd), .ext_addr_o(ext_addr),
    .ext_data_i(ext_data), .done_o(done), .bank_o(bank),
    .offset_o(offset), .status_o(status)
  );

  task automatic chk(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req_tag, act, exp);
    end
  endtask

  // full windowed transaction; scrambles request inputs after acceptance (R9)
  task automatic xact(input string tag, input logic [7:0] pg, input logic [7:0] ptr,
                      input logic [15:0] tgt, input logic [7:0] ub, input logic [7:0] ext,
                      input logic [7:0] eb, input logic [15:0] eo, input logic [1:0] es);
    @(negedge clk);
    req = 1'b1; zp_page = pg; zp_ptr = ptr; target = tgt; ubank = ub;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " R2 rd"}, ext_rd, 1);
    chk({tag, " R3 addr"}, ext_addr, {pg, ptr} ^ 16'h0C00);
    zp_page = ~pg; zp_ptr = ~ptr; target = ~tgt; ubank = ~ub;
    @(negedge clk);
    ext_data = ext;
    chk({tag, " R3 one rd"}, ext_rd, 0);
    chk({tag, " R3 no early done"}, done, 0);
    @(negedge clk);
    ext_data = ~ext;
    chk({tag, " R3 done"}, done, 1);
    chk({tag, " bank"}, bank, eb);
    chk({tag, " offset"}, offset, eo);
    chk({tag, " status"}, status, es);
    @(negedge clk);
    chk({tag, " R8 pulse"}, done, 0);
    chk({tag, " R8 ready"}, ready, 1);
  endtask

  task automatic fallback(input string tag, input logic [7:0] pg, input logic [15:0] tgt);
    @(negedge clk);
    req = 1'b1; zp_page = pg; zp_ptr = 8'h33; target = tgt;
    @(negedge clk);
    req = 1'b0;
    chk({tag, " R2 no rd"}, ext_rd, 0);
    chk({tag, " R2 done"}, done, 1);
    chk({tag, " R2 status"}, status, 3);
    chk({tag, " R2 bank"}, bank, 8'h00);
    chk({tag, " R2 offset"}, offset, tgt);
    @(negedge clk);
    chk({tag, " R8 pulse"}, done, 0);
  endtask

  task automatic t_reset;
    chk("R1 ready", ready, 1);
    chk("R1 rd", ext_rd, 0);
    chk("R1 done", done, 0);
  endtask

  task automatic t_window;
    fallback("W17", 8'h17, 16'h1234);
    fallback("W20", 8'h20, 16'hBEEF);
    xact("W18 R2", 8'h18, 8'h00, 16'h0010, 8'h00, 8'h12, 8'hFF, 16'h1810, 0);
    xact("W1F R2", 8'h1F, 8'hFF, 16'h0010, 8'h00, 8'h12, 8'hFF, 16'h1F10, 0);
  endtask

  task automatic t_special;
    xact("R4 via", 8'h1A, 8'h40, 16'hFFE0, 8'h83, 8'h8F, 8'hFF, 16'h7FE0, 0);
    xact("R4 via lo", 8'h1A, 8'h40, 16'hFFD0, 8'h83, 8'h8F, 8'hFF, 16'h7FD0, 0);
    xact("R4 low", 8'h1A, 8'h40, 16'h1000, 8'h83, 8'h8F, 8'hFF, 16'hF000, 0);
    xact("R4 high", 8'h1A, 8'h40, 16'hA000, 8'h83, 8'h8F, 8'hFF, 16'h2000, 0);
    xact("R4 top", 8'h1A, 8'h40, 16'hFFF0, 8'h83, 8'h8F, 8'hFF, 16'h7FF0, 0);
    xact("R4 raw", 8'h1A, 8'h40, 16'h5000, 8'h83, 8'h8F, 8'h00, 16'h3000, 0);
    xact("R4 raw hi", 8'h1A, 8'h40, 16'h9FFF, 8'h83, 8'h8F, 8'h00, 16'h7FFF, 0);
  endtask

  task automatic t_userbank;
    xact("R5 zp", 8'h1A, 8'h40, 16'h0042, 8'h83, 8'h85, 8'hFF, 16'h1A42, 0);
    xact("R5 bank", 8'h1A, 8'h40, 16'h4321, 8'h83, 8'h85, 8'h85, 16'h4321, 0);
    xact("R5 b80", 8'h1C, 8'h02, 16'h0100, 8'h83, 8'h80, 8'h80, 16'h0100, 0);
    xact("R5 b8E", 8'h1C, 8'h02, 16'h00FF, 8'h83, 8'h8E, 8'hFF, 16'h1CFF, 0);
  endtask

  task automatic t_sysmap;
    xact("R6 sys lo", 8'h19, 8'h10, 16'h0500, 8'h83, 8'hFF, 8'hFF, 16'hE500, 0);
    xact("R6 user", 8'h19, 8'h10, 16'h3000, 8'h83, 8'hFF, 8'h83, 16'h1000, 0);
    xact("R6 sys A", 8'h19, 8'h10, 16'hB000, 8'h83, 8'hFF, 8'hFF, 16'h3000, 0);
    xact("R6 unmap", 8'h19, 8'h10, 16'hC800, 8'h83, 8'hFF, 8'h00, 16'hC800, 1);
    xact("R6 sys D", 8'h19, 8'h10, 16'hE000, 8'h83, 8'hFF, 8'hFF, 16'h6000, 0);
    xact("R6 rom", 8'h19, 8'h10, 16'hF123, 8'h83, 8'hFF, 8'hFF, 16'hF123, 2);
  endtask

  task automatic t_other;
    xact("R7 zp", 8'h1A, 8'h40, 16'h00FF, 8'h83, 8'h12, 8'hFF, 16'h1AFF, 0);
    xact("R7 unmap", 8'h1A, 8'h40, 16'h0100, 8'h83, 8'h12, 8'h00, 16'h0100, 1);
    xact("R7 x90", 8'h1A, 8'h40, 16'h8000, 8'h83, 8'h90, 8'h00, 16'h8000, 1);
  endtask

  // req held high across a full transaction, including the done cycle (R8)
  task automatic t_busy;
    @(negedge clk);
    req = 1'b1; zp_page = 8'h1B; zp_ptr = 8'h20; target = 16'h4000; ubank = 8'h81;
    @(negedge clk);
    chk("R8 busy rd", ready, 0);
    @(negedge clk);
    ext_data = 8'h84;
    chk("R8 busy cap", ready, 0);
    @(negedge clk);
    chk("R8 done", done, 1);
    chk("R8 ready in done", ready, 0);
    chk("R8 first bank", bank, 8'h84);
    @(negedge clk);
    chk("R8 idle again", ready, 1);
    chk("R8 no rd yet", ext_rd, 0);
    @(negedge clk);
    req = 1'b0;
    chk("R8 second accept", ext_rd, 1);
    @(negedge clk);
    ext_data = 8'h12;
    @(negedge clk);
    chk("R8 second done", done, 1);
    chk("R8 second status", status, 1);
    @(negedge clk);
  endtask

  initial begin
    #50000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_window();
    t_special();
    t_userbank();
    t_sysmap();
    t_other();
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule